// File: doc/BRIEF.md
# Slave-Parallel Configuration Loader

This block is a hardware master that loads a configuration image into a downstream programmable device over an 8-bit parallel slave port. A host gives it a byte count and a start pulse, then feeds the image bytes through a valid/ready stream. The loader runs the whole sequence on its own:

- It pulses the device's active-low program line.
- It waits until the device reports that it is ready.
- It enables the write path.
- It clocks one byte per configuration-clock rising edge.
- It can hold a byte while the device signals busy.
- Once the image is sent, it keeps clocking until the device reports that configuration is done.

A status code gives the outcome: idle, running, success, or one of three timeouts. The code holds until the next start. On any timeout the loader raises an abort line and returns the device-side bus to its released levels.

A divider parameter sets the configuration-clock rate. Each low or high phase of that clock lasts `DIV` system clocks. A second parameter switches busy flow control on or off. A third sets the length of every timeout window in system clocks; the default value is 10 ms at 125 MHz.

Top module: `par_cfg_loader`

## Requirements
- R1: After reset the loader drives prog_n=1, cs_n=1, rdwr_n=1, cclk=0, abort_o=0, in_ready=0 and status=0 (idle).
- R2: A start pulse in idle sets status to 1 (running) and drives prog_n low for exactly PROG_CYCLES system clocks, then high. prog_n is low only while status is 1.
- R3: After prog_n rises, the loader waits for init_n=1 together with busy=0. If that does not happen within TMO_CYCLES clocks, status becomes 3. In that case abort_o=1, rdwr_n never goes low and no byte is written. abort_o is high only with a status of 3 or more.
- R4: Before the first byte, rdwr_n falls first. cs_n falls in a later cycle, then cclk rises in a later cycle. cs_n is never low while rdwr_n is high.
- R5: Each streamed byte is placed on dout before cclk falls, and it stays unchanged across the following rising edge. Every cclk low phase while cs_n is low lasts exactly DIV clocks. The bytes reach the bus in stream order, one rising edge per byte.
- R6: With BUSY_CHECK=1, busy=1 at the end of a high phase makes cclk keep toggling with dout held and in_ready=0 until busy=0. If busy stays high for TMO_CYCLES clocks, status becomes 4 and abort_o is set.
- R7: After the last byte, cs_n rises, and rdwr_n rises in a later cycle.
- R8: After the write path is released, cclk keeps toggling until done=1, which sets status 2 (success). If done does not arrive within TMO_CYCLES clocks, status becomes 5 and abort_o=1.
- R9: status and abort_o keep their values in idle until the next start, which clears abort_o. A start pulse during a run is ignored.
- R10: A byte count of 0 still asserts and releases cs_n, and no byte is accepted from the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a load |
| byte_count | input | CNT_W | Number of image bytes, sampled at start |
| in_data | input | 8 | Image byte from the stream source |
| in_valid | input | 1 | in_data holds a byte |
| in_ready | output | 1 | Loader takes the byte at this clock edge |
| prog_n | output | 1 | Active-low program pulse to the device |
| cs_n | output | 1 | Active-low chip select |
| rdwr_n | output | 1 | Low selects write direction |
| cclk | output | 1 | Configuration clock |
| dout | output | 8 | Configuration data bus |
| init_n | input | 1 | Device init line, high once the device is ready |
| busy | input | 1 | Device flow-control line |
| done | input | 1 | Device configuration-complete line |
| abort_o | output | 1 | Raised on any timeout |
| status | output | 3 | 0 idle, 1 running, 2 success, 3 init timeout, 4 busy timeout, 5 done timeout |

## Verification
The bench targets the sequencing corners:

- **Strobe ordering.** A loader that dropped chip select in the same cycle as the write strobe, or released them in the wrong order, would show equal or reversed edge cycle stamps.
- **Leading clock edge.** A loader that logged a byte on the edge taken before the first byte would deliver a spurious zero byte.
- **Busy hold.** A loader that ignored busy would ask for the next byte and deliver a shorter de-duplicated stream. One that never ended a hold would end in a busy timeout.
- **Empty image.** With a zero byte count, a loader that still pulled from the stream would hang or write a byte.
- **Timeout windows.** With init and done held back past the window, a loader that missed them would never leave the running state.
- **Restart during a run.** A second start while running must not trigger another program pulse.

// File: rtl/par_cfg_loader.sv
module par_cfg_loader #(
  parameter int DIV         = 2,
  parameter int PROG_CYCLES = 64,
  parameter int TMO_CYCLES  = 1250000,
  parameter int BUSY_CHECK  = 1,
  parameter int CNT_W       = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] byte_count,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             prog_n,
  output logic             cs_n,
  output logic             rdwr_n,
  output logic             cclk,
  output logic [7:0]       dout,
  input  logic             init_n,
  input  logic             busy,
  input  logic             done,
  output logic             abort_o,
  output logic [2:0]       status
);
  localparam int TLIM = (TMO_CYCLES > PROG_CYCLES) ? TMO_CYCLES : PROG_CYCLES;
  localparam int TW = $clog2(TLIM + 1);
  localparam int HW = $clog2(DIV + 1);
  localparam logic [TW-1:0] TMO_LAST  = TW'(TMO_CYCLES - 1);
  localparam logic [TW-1:0] PROG_LAST = TW'(PROG_CYCLES - 1);
  localparam logic [HW-1:0] HALF      = HW'(DIV);
  localparam logic [HW-1:0] HALF_LAST = HW'(DIV - 1);

  localparam logic [2:0] ST_IDLE = 3'd0, ST_RUN = 3'd1, ST_OK = 3'd2,
                         ST_ITMO = 3'd3, ST_BTMO = 3'd4, ST_DTMO = 3'd5;

  typedef enum logic [3:0] {
    S_IDLE, S_PROG, S_WAITI, S_WR, S_CS, S_CLKH, S_DATA,
    S_LO, S_HI, S_RELCS, S_RELWR, S_DW
  } state_t;

  state_t           state;
  logic [TW-1:0]    tmr;
  logic [HW-1:0]    hc;
  logic [CNT_W-1:0] rem;
  logic             hold;

  assign in_ready = (state == S_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; status <= ST_IDLE; abort_o <= 1'b0;
      prog_n <= 1'b1; cs_n <= 1'b1; rdwr_n <= 1'b1; cclk <= 1'b0;
      dout <= '0; rem <= '0; tmr <= '0; hc <= '0; hold <= 1'b0;
    end else begin
      case (state)
        S_IDLE:
          if (start) begin
            status <= ST_RUN; abort_o <= 1'b0; prog_n <= 1'b0;
            tmr <= '0; rem <= byte_count; state <= S_PROG;
          end
        S_PROG:
          if (tmr == PROG_LAST) begin
            prog_n <= 1'b1; tmr <= '0; state <= S_WAITI;
          end else tmr <= tmr + 1'b1;
        S_WAITI:
          if (init_n && !busy) state <= S_WR;
          else if (tmr == TMO_LAST) begin
            status <= ST_ITMO; abort_o <= 1'b1; cs_n <= 1'b1; rdwr_n <= 1'b1;
            cclk <= 1'b0; state <= S_IDLE;
          end else tmr <= tmr + 1'b1;
        S_WR:   begin rdwr_n <= 1'b0; state <= S_CS; end
        S_CS:   begin cs_n <= 1'b0; state <= S_CLKH; end
        S_CLKH: begin cclk <= 1'b1; state <= (rem == '0) ? S_RELCS : S_DATA; end
        S_DATA:
          if (in_valid) begin
            dout <= in_data; rem <= rem - 1'b1; hc <= '0; state <= S_LO;
          end
        S_LO, S_HI:
          if (hold && tmr == TMO_LAST) begin
            status <= ST_BTMO; abort_o <= 1'b1; cs_n <= 1'b1; rdwr_n <= 1'b1;
            cclk <= 1'b0; hold <= 1'b0; state <= S_IDLE;
          end else begin
            if (hold) tmr <= tmr + 1'b1;
            if (state == S_LO) begin
              if (hc == '0) begin
                cclk <= 1'b0; hc <= HW'(1);
              end else if (hc == HALF) begin
                cclk <= 1'b1; hc <= HW'(1); state <= S_HI;
              end else hc <= hc + 1'b1;
            end else if (hc == HALF) begin
              if (BUSY_CHECK != 0 && busy) begin
                if (!hold) tmr <= '0;
                hold <= 1'b1; hc <= '0; state <= S_LO;
              end else begin
                hold <= 1'b0;
                state <= (rem == '0) ? S_RELCS : S_DATA;
              end
            end else hc <= hc + 1'b1;
          end
        S_RELCS: begin cs_n <= 1'b1; state <= S_RELWR; end
        S_RELWR: begin rdwr_n <= 1'b1; tmr <= '0; hc <= '0; state <= S_DW; end
        S_DW:
          if (done) begin
            status <= ST_OK; cclk <= 1'b0; state <= S_IDLE;
          end else if (tmr == TMO_LAST) begin
            status <= ST_DTMO; abort_o <= 1'b1; cclk <= 1'b0; state <= S_IDLE;
          end else begin
            tmr <= tmr + 1'b1;
            if (hc == HALF_LAST) begin
              cclk <= ~cclk; hc <= '0;
            end else hc <= hc + 1'b1;
          end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_PROG_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |-> (status == ST_RUN)); // R2
  AST_ABORT_MEANS_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (status >= ST_ITMO)); // R3
  AST_CS_WITHIN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !rdwr_n); // R4
  AST_DATA_STABLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cclk) && !cs_n) |-> $stable(dout)); // R5
  AST_HOLD_BLOCKS_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !in_ready); // R6
  AST_BUS_FREE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (status != ST_RUN) |-> (cs_n && rdwr_n)); // R7
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !start) |=> $stable(status)); // R9
endmodule

// File: tb/tb_par_cfg_loader.sv
module tb_par_cfg_loader;
  localparam int DIV = 2, PROGC = 3, TMO = 40, CW = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, in_valid = 1'b0, busy = 1'b0;
  logic [CW-1:0] cnt_in = '0;
  logic [7:0] in_data = '0;
  logic init_n, done;
  logic in_ready, prog_n, cs_n, rdwr_n, cclk, abort_o;
  logic [7:0] dout;
  logic [2:0] status;

  par_cfg_loader #(.DIV(DIV), .PROG_CYCLES(PROGC), .TMO_CYCLES(TMO),
                   .BUSY_CHECK(1), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_count(cnt_in),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .prog_n(prog_n), .cs_n(cs_n), .rdwr_n(rdwr_n), .cclk(cclk), .dout(dout),
    .init_n(init_n), .busy(busy), .done(done), .abort_o(abort_o), .status(status));

  always #4 clk = ~clk;

  int n_chk = 0, n_err = 0;
  int iw = 0, dw = 0;
  int cyc = 0, icnt = 0, dcnt = 0, wseen = 0;
  int prog_low = 0, prog_pulses = 0, nlog = 0, lowlen = 0, low_err = 0;
  int rd_fall = 0, cs_fall = 0, first_rise = 0, cs_rise = 0, rd_rise = 0, fin_rises = 0;
  int ready_err = 0, hold_rises = 0;
  logic pk = 1'b0, pc = 1'b1, pr = 1'b1, pp = 1'b1;
  logic [7:0] logb [64];

  // device model and bus monitor, both sampled away from the active edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      init_n = 1'b0; done = 1'b0;
    end else if (!prog_n) begin
      init_n = 1'b0; done = 1'b0; icnt = 0; dcnt = 0; wseen = 0;
      if (pp) begin
        prog_pulses = prog_pulses + 1; prog_low = 0;
        nlog = 0; rd_fall = 0; cs_fall = 0; first_rise = 0; cs_rise = 0;
        rd_rise = 0; fin_rises = 0; low_err = 0; lowlen = 0;
      end
      prog_low = prog_low + 1;
    end else begin
      if (icnt >= iw) init_n = 1'b1; else icnt = icnt + 1;
      if (!rdwr_n) wseen = 1;
      if (wseen != 0 && rdwr_n) begin
        if (dcnt >= dw) done = 1'b1; else dcnt = dcnt + 1;
      end
      if (pr && !rdwr_n) rd_fall = cyc;
      if (pc && !cs_n) cs_fall = cyc;
      if (!pc && cs_n) cs_rise = cyc;
      if (!pr && rdwr_n) rd_rise = cyc;
      if (cclk && !pk && !cs_n) begin
        if (first_rise == 0) first_rise = cyc;
        else begin
          if (lowlen != DIV) low_err = low_err + 1;
          if (nlog < 64) logb[nlog] = dout;
          nlog = nlog + 1;
        end
      end
      if (cclk && !pk && cs_n && rdwr_n && status == 3'd1) fin_rises = fin_rises + 1;
      if (!cclk) lowlen = lowlen + 1; else lowlen = 0;
    end
    pk = cclk; pc = cs_n; pr = rdwr_n; pp = prog_n;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bval(input int base, input int i);
    return 8'((base + i * 37) & 255);
  endfunction

  task automatic check_log(input string req, input int n, input int base, input bit dedup);
    int k = 0, bad = 0;
    for (int j = 0; j < nlog && j < 64; j++) begin
      if (dedup && j > 0 && logb[j] == logb[j-1]) continue;
      if (k >= n || logb[j] != bval(base, k)) bad++;
      k++;
    end
    check({req, " byte count"}, k, n);
    check({req, " byte values"}, bad, 0);
  endtask

  task automatic run_case(input int n, input int base, input int iw_i, input int dw_i,
                          input int restart_at, input int busy_at, input int busy_len);
    int g = 0, nb = 0;
    iw = iw_i; dw = dw_i;
    cnt_in = CW'(n);
    start = 1'b1; @(negedge clk); start = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (i == restart_at) begin start = 1'b1; @(negedge clk); start = 1'b0; end
      if (i == busy_at) begin
        busy = 1'b1; nb = nlog; ready_err = 0;
        for (int c = 0; c < busy_len; c++) begin
          @(negedge clk);
          if (in_ready) ready_err++;
        end
        hold_rises = nlog - nb;
        busy = 1'b0;
      end
      in_data = bval(base, i); in_valid = 1'b1;
      while (!in_ready && status == 3'd1) @(negedge clk);
      if (status != 3'd1) break;
      @(negedge clk);
    end
    in_valid = 1'b0;
    while (status == 3'd1 && g < 5000) begin @(negedge clk); g++; end
    repeat (2) @(negedge clk);
  endtask

  localparam logic [31:0] VEC [5] = '{
    {8'd4, 8'h11, 8'd3,  8'd5},
    {8'd1, 8'hA5, 8'd0,  8'd0},
    {8'd6, 8'h3C, 8'd10, 8'd12},
    {8'd2, 8'h00, 8'd60, 8'd1},
    {8'd3, 8'h7E, 8'd2,  8'd80}
  };
  localparam int VEXP [5] = '{2, 2, 2, 3, 5};

  initial begin
    #(8 * 190000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    int pp0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 prog_n", int'(prog_n), 1);
    check("R1 cs_n", int'(cs_n), 1);
    check("R1 rdwr_n", int'(rdwr_n), 1);
    check("R1 cclk", int'(cclk), 0);
    check("R1 abort_o", int'(abort_o), 0);
    check("R1 in_ready", int'(in_ready), 0);
    check("R1 status", int'(status), 0);

    for (int v = 0; v < 5; v++) begin
      int n = int'(VEC[v][31:24]);
      int b = int'(VEC[v][23:16]);
      run_case(n, b, int'(VEC[v][15:8]), int'(VEC[v][7:0]), -1, -1, 0);
      check("R2 prog pulse length", prog_low, PROGC);
      check("R8 R3 final status", int'(status), VEXP[v]);
      check("R3 abort on error", int'(abort_o), (VEXP[v] >= 3) ? 1 : 0);
      if (VEXP[v] == 3) begin
        check("R3 no write after init timeout", rd_fall, 0);
        check("R3 no bytes", nlog, 0);
      end else begin
        check_log("R5", n, b, 1'b0);
        check("R5 low phase length", low_err, 0);
        check("R4 strobe order", int'(rd_fall > 0 && rd_fall < cs_fall && cs_fall < first_rise), 1);
        check("R7 release order", int'(cs_rise > 0 && rd_rise > cs_rise), 1);
        if (int'(VEC[v][7:0]) >= 8) check("R8 clocks until done", int'(fin_rises > 0), 1);
      end
    end

    // R10 zero-length image
    run_case(0, 0, 1, 3, -1, -1, 0);
    check("R10 status", int'(status), 2);
    check("R10 no byte", nlog, 0);
    check("R10 cs toggled", int'(cs_fall > 0 && cs_rise > cs_fall), 1);

    // R9 restart ignored mid-run, then status holds
    pp0 = prog_pulses;
    run_case(3, 8'h21, 1, 2, 1, -1, 0);
    check("R9 single program pulse", prog_pulses - pp0, 1);
    check("R9 abort cleared by start", int'(abort_o), 0);
    check_log("R9", 3, 8'h21, 1'b0);
    repeat (30) @(negedge clk);
    check("R9 status holds", int'(status), 2);

    // R6 busy hold
    run_case(4, 8'h05, 1, 2, -1, 1, 15);
    check("R6 status", int'(status), 2);
    check("R6 no stream pull in hold", ready_err, 0);
    check("R6 clock kept running", int'(hold_rises >= 2), 1);
    check_log("R6", 4, 8'h05, 1'b1);

    // R6 busy timeout
    run_case(3, 8'h40, 1, 2, -1, 1, 100);
    check("R6 busy timeout status", int'(status), 4);
    check("R6 busy timeout abort", int'(abort_o), 1);
    check("R6 bus released", int'(cs_n && rdwr_n), 1);
    repeat (10) @(negedge clk);
    check("R9 error status holds", int'(status), 4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule